// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one block-transfer command into a run of single-word memory accesses. A command carries a base address, a register-selection mask with one bit per register, an addressing style, a load/store direction and two options: base update and the banked-register option. After it accepts a command, the sequencer presents one access per selected register over a valid/ready handshake. Each access gives the register index and the word address. When the run ends, the block pulses a completion strobe. With that strobe it supplies the updated base value when one is requested, and a flag that asks for the status register to be restored.

The addressing style is given either directly (count up or down, step before or after the access) or by a stack name (full/empty, ascending/descending). The meaning of a stack name depends on whether the command pops (load) or pushes (store). Whatever the style, registers go out lowest index first, and the lowest index always gets the lowest address.

Top module: `lsm_seq`

## Requirements
- R1: `cmd_ready` is high only while the sequencer is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. A `cmd_valid` raised while `cmd_ready` is low changes neither the running access stream nor its result.
- R2: Every set bit of `cmd_list` produces exactly one access. Accesses come out in ascending register index, and `mem_reg` gives the index.
- R3: When `cmd_stack`=0, `cmd_sel` picks the direct style: 0 = count up, step after; 1 = count up, step before; 2 = count down, step after; 3 = count down, step before. With n set bits and base B, the first address is B, B+4, B−4n+4 and B−4n respectively.
- R4: Each access after the first has an address exactly 4 above the previous one.
- R5: When `cmd_stack`=1 and `cmd_load`=1, `cmd_sel` names a stack: 0 = full-descending, 1 = empty-descending, 2 = full-ascending, 3 = empty-ascending. These behave as up-after, up-before, down-after and down-before respectively.
- R6: When `cmd_stack`=1 and `cmd_load`=0, full-descending behaves as down-before, empty-descending as down-after, full-ascending as up-before and empty-ascending as up-after.
- R7: With `done`, `wb_en` is high exactly when `cmd_wb` was set and the mask was non-empty. `wb_value` is then B+4n for the counting-up styles and B−4n for the counting-down styles.
- R8: An empty mask produces no access, and `done` is high in the cycle right after acceptance, with `wb_en` low.
- R9: `done` is high for one cycle only, in the cycle after the last access handshake, and `cmd_ready` is high again the cycle after that.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_reg` and `mem_valid` stay unchanged.
- R11: With `cmd_caret` set, a load whose mask includes the top register (index 15) raises `psr_restore` together with `done`, and its accesses have `mem_user_bank` low. Any other command with `cmd_caret` set has `mem_user_bank` high on every access. Without `cmd_caret`, both flags stay low.
- R12: After reset the block is idle: `cmd_ready` is high, and `mem_valid`, `done`, `wb_en` and `psr_restore` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_base | input | AW | Base address |
| cmd_list | input | NREG | Register-selection mask |
| cmd_stack | input | 1 | 1: `cmd_sel` is a stack name; 0: a direct style |
| cmd_sel | input | 2 | Addressing style or stack name |
| cmd_load | input | 1 | 1 load (pop), 0 store (push) |
| cmd_wb | input | 1 | Request the updated base |
| cmd_caret | input | 1 | Banked-register / status-restore option |
| mem_valid | output | 1 | Access request |
| mem_ready | input | 1 | Access accepted |
| mem_addr | output | AW | Word address of the access |
| mem_reg | output | IDX_W | Register index of the access |
| mem_load | output | 1 | Access direction |
| mem_user_bank | output | 1 | Access targets the user register bank |
| done | output | 1 | One-cycle completion strobe |
| wb_en | output | 1 | Updated base is valid (with `done`) |
| wb_value | output | AW | Updated base value |
| psr_restore | output | 1 | Restore status register (with `done`) |

## Verification
The assertions check the handshake rules on every cycle. A stalled request must hold still. After each accepted access, the next one must sit 4 bytes higher and carry a strictly larger index. `done` must last one cycle, and the block never offers an access while it shows ready for a command. Only the bench's scenarios can show the absolute start addresses, the stack-name mapping for each direction, the updated base value, that each set bit gets exactly one access, and the caret flags. The scoreboard compares these against values it computes itself.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        AM_UP_AFTER    = 2'd0,
        AM_UP_BEFORE   = 2'd1,
        AM_DOWN_AFTER  = 2'd2,
        AM_DOWN_BEFORE = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        STK_FULL_DESC  = 2'd0,
        STK_EMPTY_DESC = 2'd1,
        STK_FULL_ASC   = 2'd2,
        STK_EMPTY_ASC  = 2'd3
    } stack_name_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_e;

    function automatic int unsigned count_ones(input logic [31:0] v);
        int unsigned c;
        c = 0;
        for (int i = 0; i < 32; i++) begin
            c += int'(v[i]);
        end
        return c;
    endfunction

    function automatic logic mode_is_down(input addr_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_before(input addr_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode
    import lsm_pkg::*;
(
    input  logic       stack_form,
    input  logic [1:0] sel,
    input  logic       is_load,
    output addr_mode_e mode
);
    // Pops take the stack name unchanged; pushes take its bitwise complement.
    always_comb begin
        if (!stack_form) begin
            mode = addr_mode_e'(sel);
        end else if (is_load) begin
            mode = addr_mode_e'(sel);
        end else begin
            mode = addr_mode_e'(~sel);
        end
    end
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
    import lsm_pkg::*;
#(
    parameter int AW         = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0]   base,
    input  logic [NREG-1:0] list,
    input  addr_mode_e      mode,
    output logic [AW-1:0]   start_addr,
    output logic [AW-1:0]   new_base
);
    localparam int CNT_W = $clog2(NREG + 1);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [CNT_W-1:0] n_sel;
    logic [AW-1:0]    span;

    always_comb begin
        n_sel = CNT_W'(count_ones(32'(list)));
        span  = AW'(n_sel) * STEP;
        unique case (mode)
            AM_UP_AFTER:    start_addr = base;
            AM_UP_BEFORE:   start_addr = base + STEP;
            AM_DOWN_AFTER:  start_addr = base - span + STEP;
            default:        start_addr = base - span;
        endcase
        new_base = mode_is_down(mode) ? (base - span) : (base + span);
    end
endmodule

// File: rtl/lsm_reg_pick.sv
module lsm_reg_pick #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [NREG-1:0] lower_any;
    logic [NREG-1:0] first_hot;

    assign lower_any[0] = 1'b0;
    assign first_hot[0] = mask[0];

    for (genvar i = 1; i < NREG; i++) begin : g_chain
        assign lower_any[i] = lower_any[i-1] | mask[i-1];
        assign first_hot[i] = mask[i] & ~lower_any[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (first_hot[i]) idx = idx | IDX_W'(i);
        end
        found = |mask;
    end

    always_comb begin
        // R2
        pick_in_mask_chk: assert (!found || mask[idx]);
    end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int AW         = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [AW-1:0]    cmd_base,
    input  logic [NREG-1:0]  cmd_list,
    input  logic             cmd_stack,
    input  logic [1:0]       cmd_sel,
    input  logic             cmd_load,
    input  logic             cmd_wb,
    input  logic             cmd_caret,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [AW-1:0]    mem_addr,
    output logic [IDX_W-1:0] mem_reg,
    output logic             mem_load,
    output logic             mem_user_bank,
    output logic             done,
    output logic             wb_en,
    output logic [AW-1:0]    wb_value,
    output logic             psr_restore
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    addr_mode_e      mode_d;
    logic [AW-1:0]   start_d;
    logic [AW-1:0]   newbase_d;
    logic            pick_found;
    logic [IDX_W-1:0] pick_idx;

    seq_state_e      state_q;
    logic [NREG-1:0] rem_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wbv_q;
    logic            wbreq_q;
    logic            load_q;
    logic            user_q;
    logic            psr_q;

    logic            accept;
    logic            fire;
    logic [NREG-1:0] rem_next;
    logic            top_sel;

    lsm_mode_decode u_dec (
        .stack_form (cmd_stack),
        .sel        (cmd_sel),
        .is_load    (cmd_load),
        .mode       (mode_d)
    );

    lsm_addr_plan #(.AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base       (cmd_base),
        .list       (cmd_list),
        .mode       (mode_d),
        .start_addr (start_d),
        .new_base   (newbase_d)
    );

    lsm_reg_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
        .mask  (rem_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign cmd_ready = (state_q == SQ_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign mem_valid = (state_q == SQ_RUN);
    assign fire      = mem_valid && mem_ready;
    assign rem_next  = rem_q & (rem_q - NREG'(1));
    assign top_sel   = cmd_list[NREG-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            rem_q   <= '0;
            addr_q  <= '0;
            wbv_q   <= '0;
            wbreq_q <= 1'b0;
            load_q  <= 1'b0;
            user_q  <= 1'b0;
            psr_q   <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        rem_q   <= cmd_list;
                        addr_q  <= start_d;
                        wbv_q   <= newbase_d;
                        wbreq_q <= cmd_wb && (|cmd_list);
                        load_q  <= cmd_load;
                        user_q  <= cmd_caret && !(cmd_load && top_sel);
                        psr_q   <= cmd_caret && cmd_load && top_sel;
                        state_q <= (|cmd_list) ? SQ_RUN : SQ_FIN;
                    end
                end
                SQ_RUN: begin
                    if (fire) begin
                        rem_q  <= rem_next;
                        addr_q <= addr_q + STEP;
                        if (rem_next == '0) state_q <= SQ_FIN;
                    end
                end
                default: begin
                    state_q <= SQ_IDLE;
                end
            endcase
        end
    end

    assign mem_addr      = addr_q;
    assign mem_reg       = pick_idx;
    assign mem_load      = load_q;
    assign mem_user_bank = user_q;
    assign done          = (state_q == SQ_FIN);
    assign wb_en         = done && wbreq_q;
    assign wb_value      = wbv_q;
    assign psr_restore   = done && psr_q;

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_reg));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ready |=> !mem_valid || (mem_addr == $past(mem_addr) + STEP));

    // R2
    reg_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ready |=> !mem_valid || (mem_reg > $past(mem_reg)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && cmd_ready);

    // R1
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_ready && mem_valid));

    // R2
    valid_has_reg_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> pick_found);

    // R11
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        psr_restore |-> done && mem_load && !mem_user_bank);
endmodule

// File: tb/sim_lsm_seq.sv
module sim_lsm_seq;
    localparam int AW = 32;
    localparam int NREG = 16;
    localparam int IDX_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [AW-1:0]    cmd_base = '0;
    logic [NREG-1:0]  cmd_list = '0;
    logic             cmd_stack = 1'b0;
    logic [1:0]       cmd_sel = '0;
    logic             cmd_load = 1'b0;
    logic             cmd_wb = 1'b0;
    logic             cmd_caret = 1'b0;
    logic             mem_valid;
    logic             mem_ready = 1'b0;
    logic [AW-1:0]    mem_addr;
    logic [IDX_W-1:0] mem_reg;
    logic             mem_load;
    logic             mem_user_bank;
    logic             done;
    logic             wb_en;
    logic [AW-1:0]    wb_value;
    logic             psr_restore;

    lsm_seq u0 (.*);

    typedef struct packed {
        logic [IDX_W-1:0] rg;
        logic [AW-1:0]    ad;
    } acc_t;

    acc_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    logic exp_load = 1'b0;
    logic exp_user = 1'b0;
    string cur_tag = "";
    logic [7:0] lfsr = 8'h5B;
    logic force_ready = 1'b0;
    logic stall_seen = 1'b0;
    logic [AW-1:0] stall_addr = '0;
    logic [IDX_W-1:0] stall_reg = '0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s (%s): actual %0h expected %0h", req, cur_tag, act, expv);
        end
    endtask

    // Monitor: decides mem_ready, then scores the access that completes at the next edge.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = force_ready | lfsr[0];
        if (!rst && stall_seen) begin
            // R10
            check("R10 stall valid", 64'(mem_valid), 64'd1);
            check("R10 stall addr", 64'(mem_addr), 64'(stall_addr));
            check("R10 stall reg", 64'(mem_reg), 64'(stall_reg));
        end
        stall_seen = 1'b0;
        if (!rst && mem_valid) begin
            if (!mem_ready) begin
                stall_seen = 1'b1;
                stall_addr = mem_addr;
                stall_reg  = mem_reg;
            end else if (exp_q.size() == 0) begin
                check("R2 unexpected access", 64'(mem_reg), 64'hFFFF);
            end else begin
                acc_t e;
                e = exp_q.pop_front();
                // R2 R3 R4 R5 R6
                check("R2 reg index", 64'(mem_reg), 64'(e.rg));
                check("R3 address", 64'(mem_addr), 64'(e.ad));
                check("R11 user bank", 64'(mem_user_bank), 64'(exp_user));
                check("R1 direction", 64'(mem_load), 64'(exp_load));
            end
        end
    end

    task automatic run_cmd(input string tag, input logic stk, input logic [1:0] sel,
                           input logic ld, input logic wb, input logic caret,
                           input logic [AW-1:0] base, input logic [NREG-1:0] list,
                           input logic poke);
        logic [1:0] m;
        int n;
        logic [AW-1:0] start, nb;
        logic exp_psr;
        n = 0;
        for (int i = 0; i < NREG; i++) n += int'(list[i]);
        m = (stk && !ld) ? ~sel : sel;
        case (m)
            2'd0: start = base;
            2'd1: start = base + 4;
            2'd2: start = base - AW'(4 * n) + 4;
            default: start = base - AW'(4 * n);
        endcase
        nb = m[1] ? base - AW'(4 * n) : base + AW'(4 * n);
        exp_psr = caret && ld && list[15];
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cur_tag  = tag;
        exp_load = ld;
        exp_user = caret && !(ld && list[15]);
        begin
            int k;
            k = 0;
            for (int i = 0; i < NREG; i++) begin
                if (list[i]) begin
                    exp_q.push_back('{rg: IDX_W'(i), ad: start + AW'(4 * k)});
                    k++;
                end
            end
        end
        cmd_base = base; cmd_list = list; cmd_stack = stk; cmd_sel = sel;
        cmd_load = ld; cmd_wb = wb; cmd_caret = caret; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (n == 0) begin
            // R8
            check("R8 done right after accept", 64'(done), 64'd1);
        end else begin
            check("R1 busy after accept", 64'(cmd_ready), 64'd0);
        end
        if (poke) begin
            for (int j = 0; j < 3; j++) begin
                cmd_base = 32'hDEAD_0000; cmd_list = 16'h0001; cmd_sel = 2'd3; cmd_load = !ld;
                cmd_valid = 1'b1;
                // R1
                check("R1 not ready while busy", 64'(cmd_ready), 64'd0);
                @(negedge clk);
            end
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        // R7 R11 R2
        check("R7 wb_en", 64'(wb_en), 64'(wb && n != 0));
        if (wb && n != 0) check("R7 wb_value", 64'(wb_value), 64'(nb));
        check("R11 psr_restore", 64'(psr_restore), 64'(exp_psr));
        check("R2 all accesses done", 64'(exp_q.size()), 64'd0);
        @(negedge clk);
        // R9
        check("R9 done one cycle", 64'(done), 64'd0);
        check("R9 ready again", 64'(cmd_ready), 64'd1);
    endtask

    int cycles = 0;
    logic timed_out = 1'b0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !timed_out) begin
            timed_out = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12
        cur_tag = "reset";
        check("R12 cmd_ready", 64'(cmd_ready), 64'd1);
        check("R12 mem_valid", 64'(mem_valid), 64'd0);
        check("R12 done", 64'(done), 64'd0);
        check("R12 wb_en", 64'(wb_en), 64'd0);
        check("R12 psr_restore", 64'(psr_restore), 64'd0);
        // R3 direct styles
        run_cmd("R3 up-after",     1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_1000, 16'h0005, 1'b0);
        run_cmd("R3 up-before",    1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 32'h0000_2000, 16'h8102, 1'b0);
        run_cmd("R3 down-after",   1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_3000, 16'h00F0, 1'b0);
        run_cmd("R3 down-before",  1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 32'h0000_4000, 16'h4009, 1'b0);
        // R5 pops by stack name
        run_cmd("R5 pop full-desc",  1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_5000, 16'h0033, 1'b0);
        run_cmd("R5 pop empty-desc", 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 32'h0000_5100, 16'h0300, 1'b0);
        run_cmd("R5 pop full-asc",   1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 32'h0000_5200, 16'h0C01, 1'b0);
        run_cmd("R5 pop empty-asc",  1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 32'h0000_5300, 16'h1010, 1'b0);
        // R6 pushes by stack name
        run_cmd("R6 push full-desc",  1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_6000, 16'h0033, 1'b0);
        run_cmd("R6 push empty-desc", 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0000_6100, 16'h0300, 1'b0);
        run_cmd("R6 push full-asc",   1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_6200, 16'h0C01, 1'b0);
        run_cmd("R6 push empty-asc",  1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 32'h0000_6300, 16'h1010, 1'b0);
        // R1 full list with commands offered while busy; R4 long run
        run_cmd("R1 R4 full list poked", 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 32'h0000_8000, 16'hFFFF, 1'b1);
        // R8 empty list, writeback requested but not granted
        run_cmd("R8 empty list", 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 32'h0000_9000, 16'h0000, 1'b0);
        // R7 no writeback requested
        run_cmd("R7 no wb", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_A000, 16'h0006, 1'b0);
        // R11 caret variants
        run_cmd("R11 caret load top", 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_B000, 16'h8001, 1'b0);
        run_cmd("R11 caret load no top", 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_B100, 16'h0003, 1'b0);
        run_cmd("R11 caret store top", 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0000_B200, 16'h8000, 1'b0);
        // R9 back-to-back with ready always high
        force_ready = 1'b1;
        run_cmd("R9 fast single", 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC, 16'h0400, 1'b0);
        run_cmd("R9 fast pair",   1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 32'h0000_0004, 16'h0081, 1'b0);
        force_ready = 1'b0;
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule